// File: doc/BRIEF.md
# Half-Precision Operand Register Access

This block sits between a floating-point execution unit and the architectural register state. It holds two register files: a floating-point file of `FLEN`-wide entries and an integer file of `XLEN`-wide entries. Operands of 16, 32 or 64 bits are read on three combinational read ports and written on one clocked write port. Two static enables select the file. With the separate floating-point file, narrow values are stored with every bit above the operand filled with ones (NaN-boxed). On reads, the upper bits are checked, and a value whose upper bits are not all ones returns the canonical NaN. With the shared integer file, narrow values are sign-extended on write and truncated on read, with no NaN check.

Exactly one of the two enables must be set. The block reports any other setting and then refuses all accesses. The execution unit selects the operand width on every port. The result is placed in the low bits of a 64-bit bus, and the bits above the operand width are zero.

Top module: `hp_operand_access`

## Requirements
- R1: When `fp_en_i` and `int_en_i` are equal (both set or both clear), `cfg_err_o` is 1, every read port returns zero, and writes change neither register file.
- R2: In floating-point mode (`fp_en_i`=1, `int_en_i`=0), a write of width n bits stores the low n bits of `wr_data_i` with all bits from n up to FLEN-1 set to ones.
- R3: In floating-point mode, a read of width n returns the low n bits of the addressed entry, zero-extended to 64 bits, when bits n to FLEN-1 of that entry are all ones.
- R4: In floating-point mode, a read of width n whose entry has any zero in bits n to FLEN-1 returns the canonical NaN: 0x7E00 for half and 0x7FC00000 for single.
- R5: In integer mode (`int_en_i`=1, `fp_en_i`=0), a write of width n stores the low n bits of `wr_data_i` sign-extended from bit n-1 to XLEN bits.
- R6: In integer mode, a read of width n returns the low n bits of the addressed entry, zero-extended to 64 bits, regardless of its upper bits.
- R7: In integer mode, a write to index 0 is discarded and a read of index 0 returns zero.
- R8: Writes take effect at the rising clock edge on which `wr_en_i` is high. Reads are combinational, so a read in the same cycle as the write sees the old value. The three read ports are independent.
- R9: Width codes are 2'b00 half (16), 2'b01 single (32), 2'b10 double (64), and 2'b11 reserved. A reserved read returns zero, and a reserved write is ignored.
- R10: Reset (`rst_ni` low) clears every entry of both files to zero. A half read of a cleared floating-point entry therefore returns 0x7E00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fp_en_i | input | 1 | Select the separate floating-point file |
| int_en_i | input | 1 | Select the shared integer file |
| rd_addr_i | input | NUM_RD x AW | Read index per port |
| rd_width_i | input | NUM_RD x 2 | Read width code per port |
| rd_data_o | output | NUM_RD x 64 | Formatted read operand per port |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | AW | Write index |
| wr_width_i | input | 2 | Write width code |
| wr_data_i | input | 64 | Write operand in the low bits |
| cfg_err_o | output | 1 | Both or neither file enabled |

## Verification
On every cycle, the assertions check four things on each read port: reads are zero under a bad configuration, reserved widths return zero, index 0 is zero in integer mode, and half reads leave the upper 48 bits clear. They also check that a half write read back one cycle later at double width is boxed with ones in floating-point mode and sign-extended in integer mode. The remaining behaviour is shown only by the bench scenarios. This covers the canonical NaN for single and half reads of wrongly boxed entries, writes refused under a bad configuration or a reserved width, the same-cycle old-value read, and the reset contents. The bench sweeps every index at every width in both modes.

// File: rtl/hp_pkg.sv
package hp_pkg;

  localparam int unsigned OPD_W = 64;

  typedef enum logic [1:0] {
    OPW_HALF   = 2'b00,
    OPW_SINGLE = 2'b01,
    OPW_DOUBLE = 2'b10,
    OPW_RSVD   = 2'b11
  } opw_e;

  function automatic int unsigned opw_bits(opw_e w);
    case (w)
      OPW_HALF:   return 16;
      OPW_SINGLE: return 32;
      OPW_DOUBLE: return 64;
      default:    return 0;
    endcase
  endfunction

  function automatic logic [OPD_W-1:0] low_mask(opw_e w);
    case (w)
      OPW_HALF:   return 64'h0000_0000_0000_FFFF;
      OPW_SINGLE: return 64'h0000_0000_FFFF_FFFF;
      OPW_DOUBLE: return 64'hFFFF_FFFF_FFFF_FFFF;
      default:    return '0;
    endcase
  endfunction

  function automatic logic [OPD_W-1:0] canon_nan(opw_e w);
    case (w)
      OPW_HALF:   return 64'h0000_0000_0000_7E00;
      OPW_SINGLE: return 64'h0000_0000_7FC0_0000;
      OPW_DOUBLE: return 64'h7FF8_0000_0000_0000;
      default:    return '0;
    endcase
  endfunction

  function automatic logic sign_of(opw_e w, logic [OPD_W-1:0] d);
    case (w)
      OPW_HALF:   return d[15];
      OPW_SINGLE: return d[31];
      OPW_DOUBLE: return d[63];
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/hp_regfile.sv
module hp_regfile #(
  parameter int unsigned NREGS    = 32,
  parameter int unsigned DW       = 64,
  parameter int unsigned NRD      = 3,
  parameter int unsigned AW       = 5,
  parameter bit          ZERO_REG = 1'b0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [AW-1:0]           waddr_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic [NRD-1:0][AW-1:0]  raddr_i,
  output logic [NRD-1:0][DW-1:0]  rdata_o
);

  localparam logic [AW:0] NREGS_L = (AW+1)'(NREGS);

  logic [NREGS-1:0][DW-1:0] mem_q;
  logic                     wr_hit;

  always_comb begin
    wr_hit = we_i && ({1'b0, waddr_i} < NREGS_L);
    if (ZERO_REG && (waddr_i == '0)) wr_hit = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= '0;
    else if (wr_hit) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      rdata_o[p] = '0;
      if ({1'b0, raddr_i[p]} < NREGS_L) rdata_o[p] = mem_q[raddr_i[p]];
      if (ZERO_REG && (raddr_i[p] == '0)) rdata_o[p] = '0;
    end
  end

endmodule

// File: rtl/hp_rd_fmt.sv
module hp_rd_fmt
  import hp_pkg::*;
#(
  parameter int unsigned FLEN = 64,
  parameter int unsigned XLEN = 64
) (
  input  logic             legal_i,
  input  logic             int_mode_i,
  input  opw_e             width_i,
  input  logic [FLEN-1:0]  fp_word_i,
  input  logic [XLEN-1:0]  x_word_i,
  output logic [OPD_W-1:0] data_o
);

  logic [OPD_W-1:0] mask;
  logic [OPD_W-1:0] fp_ext;
  logic [OPD_W-1:0] x_ext;
  logic             fp_boxed;
  int unsigned      nbits;

  always_comb begin
    mask     = low_mask(width_i);
    nbits    = opw_bits(width_i);
    fp_ext   = OPD_W'(fp_word_i);
    x_ext    = OPD_W'(x_word_i);
    // every bit above the operand must be one
    fp_boxed = &(fp_word_i | mask[FLEN-1:0]);
    data_o   = '0;
    if (legal_i && (nbits != 0)) begin
      if (int_mode_i) begin
        if (nbits <= XLEN) data_o = x_ext & mask;
      end else if (nbits <= FLEN) begin
        data_o = fp_boxed ? (fp_ext & mask) : canon_nan(width_i);
      end
    end
  end

endmodule

// File: rtl/hp_wr_fmt.sv
module hp_wr_fmt
  import hp_pkg::*;
#(
  parameter int unsigned FLEN = 64,
  parameter int unsigned XLEN = 64
) (
  input  opw_e             width_i,
  input  logic [OPD_W-1:0] data_i,
  output logic [FLEN-1:0]  fp_val_o,
  output logic [XLEN-1:0]  x_val_o,
  output logic             fp_ok_o,
  output logic             x_ok_o
);

  logic [OPD_W-1:0] mask;
  logic [OPD_W-1:0] boxed;
  logic [OPD_W-1:0] sext;
  int unsigned      nbits;

  always_comb begin
    mask     = low_mask(width_i);
    nbits    = opw_bits(width_i);
    boxed    = (data_i & mask) | ~mask;
    sext     = (data_i & mask) | (sign_of(width_i, data_i) ? ~mask : '0);
    fp_val_o = boxed[FLEN-1:0];
    x_val_o  = sext[XLEN-1:0];
    fp_ok_o  = (nbits != 0) && (nbits <= FLEN);
    x_ok_o   = (nbits != 0) && (nbits <= XLEN);
  end

endmodule

// File: rtl/hp_operand_access.sv
module hp_operand_access
  import hp_pkg::*;
#(
  parameter int unsigned NREGS  = 32,
  parameter int unsigned FLEN   = 64,
  parameter int unsigned XLEN   = 64,
  parameter int unsigned NUM_RD = 3,
  localparam int unsigned AW    = $clog2(NREGS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          fp_en_i,
  input  logic                          int_en_i,
  input  logic [NUM_RD-1:0][AW-1:0]     rd_addr_i,
  input  logic [NUM_RD-1:0][1:0]        rd_width_i,
  output logic [NUM_RD-1:0][OPD_W-1:0]  rd_data_o,
  input  logic                          wr_en_i,
  input  logic [AW-1:0]                 wr_addr_i,
  input  logic [1:0]                    wr_width_i,
  input  logic [OPD_W-1:0]              wr_data_i,
  output logic                          cfg_err_o
);

  logic legal;
  logic int_mode;

  assign legal     = fp_en_i ^ int_en_i;
  assign int_mode  = int_en_i;
  assign cfg_err_o = ~legal;

  logic [FLEN-1:0] wr_fp_val;
  logic [XLEN-1:0] wr_x_val;
  logic            wr_fp_ok;
  logic            wr_x_ok;
  logic            fp_we;
  logic            x_we;

  hp_wr_fmt #(.FLEN(FLEN), .XLEN(XLEN)) i_wr_fmt (
    .width_i  (opw_e'(wr_width_i)),
    .data_i   (wr_data_i),
    .fp_val_o (wr_fp_val),
    .x_val_o  (wr_x_val),
    .fp_ok_o  (wr_fp_ok),
    .x_ok_o   (wr_x_ok)
  );

  assign fp_we = wr_en_i && legal && !int_mode && wr_fp_ok;
  assign x_we  = wr_en_i && legal && int_mode && wr_x_ok;

  logic [NUM_RD-1:0][FLEN-1:0] fp_rdata;
  logic [NUM_RD-1:0][XLEN-1:0] x_rdata;

  hp_regfile #(
    .NREGS(NREGS), .DW(FLEN), .NRD(NUM_RD), .AW(AW), .ZERO_REG(1'b0)
  ) i_fp_file (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (fp_we),
    .waddr_i (wr_addr_i),
    .wdata_i (wr_fp_val),
    .raddr_i (rd_addr_i),
    .rdata_o (fp_rdata)
  );

  hp_regfile #(
    .NREGS(NREGS), .DW(XLEN), .NRD(NUM_RD), .AW(AW), .ZERO_REG(1'b1)
  ) i_x_file (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (x_we),
    .waddr_i (wr_addr_i),
    .wdata_i (wr_x_val),
    .raddr_i (rd_addr_i),
    .rdata_o (x_rdata)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_port
    hp_rd_fmt #(.FLEN(FLEN), .XLEN(XLEN)) i_rd_fmt (
      .legal_i    (legal),
      .int_mode_i (int_mode),
      .width_i    (opw_e'(rd_width_i[p])),
      .fp_word_i  (fp_rdata[p]),
      .x_word_i   (x_rdata[p]),
      .data_o     (rd_data_o[p])
    );
  end

endmodule

// File: rtl/hp_operand_access_chk.sv
module hp_operand_access_chk #(
  parameter int unsigned NREGS  = 32,
  parameter int unsigned FLEN   = 64,
  parameter int unsigned XLEN   = 64,
  parameter int unsigned NUM_RD = 3,
  parameter int unsigned AW     = 5
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      fp_en_i,
  input logic                      int_en_i,
  input logic [NUM_RD-1:0][AW-1:0] rd_addr_i,
  input logic [NUM_RD-1:0][1:0]    rd_width_i,
  input logic [NUM_RD-1:0][63:0]   rd_data_o,
  input logic                      wr_en_i,
  input logic [AW-1:0]             wr_addr_i,
  input logic [1:0]                wr_width_i,
  input logic [63:0]               wr_data_i,
  input logic                      cfg_err_o
);

  logic fp_mode;
  logic x_mode;
  assign fp_mode = fp_en_i && !int_en_i;
  assign x_mode  = int_en_i && !fp_en_i;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_chk
    // R1
    bad_cfg_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fp_en_i == int_en_i) |-> (cfg_err_o && (rd_data_o[p] == '0)));

    // R9
    rsvd_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_width_i[p] == 2'b11) |-> (rd_data_o[p] == '0));

    // R7
    x0_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (x_mode && (rd_addr_i[p] == '0)) |-> (rd_data_o[p] == '0));

    // R3
    half_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_width_i[p] == 2'b00) |-> (rd_data_o[p][63:16] == '0));

    if (XLEN == 64) begin : g_sx
      // R5
      sext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(wr_en_i && x_mode && (wr_width_i == 2'b00) && (wr_addr_i != '0))
         && x_mode && (rd_addr_i[p] == $past(wr_addr_i)) && (rd_width_i[p] == 2'b10))
        |-> (rd_data_o[p] == {{48{$past(wr_data_i[15])}}, $past(wr_data_i[15:0])}));
    end

    if (FLEN == 64) begin : g_bx
      // R2
      box_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(wr_en_i && fp_mode && (wr_width_i == 2'b00))
         && fp_mode && (rd_addr_i[p] == $past(wr_addr_i)) && (rd_width_i[p] == 2'b10))
        |-> (rd_data_o[p] == {48'hFFFF_FFFF_FFFF, $past(wr_data_i[15:0])}));
    end
  end

endmodule

bind hp_operand_access hp_operand_access_chk #(
  .NREGS(NREGS), .FLEN(FLEN), .XLEN(XLEN), .NUM_RD(NUM_RD), .AW(AW)
) i_hp_operand_access_chk (.*);

// File: tb/test_hp_operand_access.sv
module test_hp_operand_access;

  localparam int NREGS = 32;
  localparam int NRD   = 3;
  localparam int AW    = 5;

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic                    fp_en_i = 1'b1;
  logic                    int_en_i = 1'b0;
  logic [NRD-1:0][AW-1:0]  rd_addr_i = '0;
  logic [NRD-1:0][1:0]     rd_width_i = '0;
  logic [NRD-1:0][63:0]    rd_data_o;
  logic                    wr_en_i = 1'b0;
  logic [AW-1:0]           wr_addr_i = '0;
  logic [1:0]              wr_width_i = '0;
  logic [63:0]             wr_data_i = '0;
  logic                    cfg_err_o;

  hp_operand_access i_hp_operand_access (.*);

  always #4 clk_i = ~clk_i;

  int errors = 0;
  int checks = 0;
  logic [63:0] fp_m [NREGS];
  logic [63:0] x_m  [NREGS];

  function automatic logic [63:0] mask_of(logic [1:0] w);
    case (w)
      2'b00: return 64'hFFFF;
      2'b01: return 64'hFFFF_FFFF;
      2'b10: return '1;
      default: return '0;
    endcase
  endfunction

  function automatic logic [63:0] exp_rd(int a, logic [1:0] w);
    logic [63:0] m;
    m = mask_of(w);
    if (fp_en_i == int_en_i || w == 2'b11) return '0;
    if (int_en_i) return (a == 0) ? 64'd0 : (x_m[a] & m);
    if ((fp_m[a] | m) == '1) return fp_m[a] & m;
    return (w == 2'b00) ? 64'h7E00 : 64'h7FC0_0000;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd3(string tag, int a0, logic [1:0] w0, int a1, logic [1:0] w1,
                     int a2, logic [1:0] w2);
    @(negedge clk_i);
    rd_addr_i[0] = AW'(a0); rd_width_i[0] = w0;
    rd_addr_i[1] = AW'(a1); rd_width_i[1] = w1;
    rd_addr_i[2] = AW'(a2); rd_width_i[2] = w2;
    #1;
    check(tag, rd_data_o[0], exp_rd(a0, w0));
    check(tag, rd_data_o[1], exp_rd(a1, w1));
    check(tag, rd_data_o[2], exp_rd(a2, w2));
  endtask

  task automatic wr(int a, logic [1:0] w, logic [63:0] d);
    logic [63:0] m;
    logic sgn;
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = AW'(a); wr_width_i = w; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    m = mask_of(w);
    if (fp_en_i != int_en_i && w != 2'b11) begin
      if (fp_en_i) fp_m[a] = (d & m) | ~m;
      else if (a != 0) begin
        sgn = (w == 2'b00) ? d[15] : (w == 2'b01) ? d[31] : d[63];
        x_m[a] = (d & m) | (sgn ? ~m : 64'd0);
      end
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NREGS; i++) begin fp_m[i] = '0; x_m[i] = '0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R10 reset contents, R4 cleared entry reads as canonical NaN
    rd3("R10", 5, 2'b00, 7, 2'b01, 9, 2'b10);
    check("R10 half nan", rd_data_o[0], 64'h7E00);
    fp_en_i = 1'b0; int_en_i = 1'b1;
    rd3("R10 int", 5, 2'b00, 31, 2'b10, 0, 2'b01);
    fp_en_i = 1'b1; int_en_i = 1'b0;

    // R2 R3 R8 floating-point half sweep, three ports
    for (int r = 0; r < NREGS; r++) wr(r, 2'b00, 64'(r * 16'h0531 + 16'h1234));
    for (int r = 0; r < NREGS; r++) rd3("R2/R3", r, 2'b00, r, 2'b01, (r + 1) % NREGS, 2'b10);

    // R4 single values read as half: boxed or not
    wr(3, 2'b01, 64'h4049_0FDB);
    wr(4, 2'b01, 64'hFFFF_1234);
    rd3("R4", 3, 2'b00, 4, 2'b00, 3, 2'b01);
    check("R4 nan half", rd_data_o[0], 64'h7E00);
    check("R3 boxed single", rd_data_o[1], 64'h1234);
    // R4 double read as single
    wr(6, 2'b10, 64'h4009_21FB_5444_2D18);
    wr(7, 2'b10, 64'hFFFF_FFFF_3F80_0000);
    rd3("R4 dbl", 6, 2'b01, 7, 2'b01, 6, 2'b10);
    check("R4 nan single", rd_data_o[0], 64'h7FC0_0000);

    // R9 reserved width
    wr(8, 2'b11, 64'h5555);
    rd3("R9", 8, 2'b11, 8, 2'b10, 8, 2'b00);

    // R8 same-cycle write sees old value
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 5'd10; wr_width_i = 2'b00; wr_data_i = 64'hABCD;
    rd_addr_i[0] = 5'd10; rd_width_i[0] = 2'b00;
    #1;
    check("R8 old", rd_data_o[0], fp_m[10] & 64'hFFFF);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    fp_m[10] = 64'hFFFF_FFFF_FFFF_ABCD;
    #1;
    check("R8 new", rd_data_o[0], 64'hABCD);

    // R5 R6 R7 integer mode sweep
    fp_en_i = 1'b0; int_en_i = 1'b1;
    for (int r = 0; r < NREGS; r++) wr(r, 2'b00, 64'(r * 16'h0A11 + 16'h7F80));
    for (int r = 0; r < NREGS; r++) rd3("R5/R6/R7", r, 2'b10, r, 2'b00, r, 2'b01);
    wr(12, 2'b01, 64'h8000_0001);
    rd3("R5 single", 12, 2'b10, 12, 2'b00, 0, 2'b10);
    check("R5 sext", rd_data_o[0], 64'hFFFF_FFFF_8000_0001);
    wr(13, 2'b10, 64'h1234_5678_9ABC_DEF0);
    rd3("R6", 13, 2'b00, 13, 2'b01, 13, 2'b10);
    check("R6 trunc", rd_data_o[0], 64'hDEF0);
    wr(0, 2'b10, 64'hFFFF);
    rd3("R7", 0, 2'b10, 0, 2'b00, 13, 2'b00);
    check("R7 x0", rd_data_o[0], 64'd0);

    // R1 both enabled, then neither
    fp_en_i = 1'b1; int_en_i = 1'b1;
    #1; check("R1 err flag", 64'(cfg_err_o), 64'd1);
    wr(14, 2'b10, 64'hDEAD_BEEF);
    rd3("R1 both", 14, 2'b10, 13, 2'b10, 2, 2'b00);
    fp_en_i = 1'b0; int_en_i = 1'b0;
    #1; check("R1 err flag none", 64'(cfg_err_o), 64'd1);
    wr(15, 2'b00, 64'h1111);
    fp_en_i = 1'b0; int_en_i = 1'b1;
    #1; check("R1 err clear", 64'(cfg_err_o), 64'd0);
    rd3("R1 int kept", 14, 2'b10, 15, 2'b10, 13, 2'b10);
    fp_en_i = 1'b1; int_en_i = 1'b0;
    rd3("R1 fp kept", 14, 2'b10, 15, 2'b10, 10, 2'b10);

    finish_run();
  end

endmodule